// File: doc/BRIEF.md
# Hardwired 8-bit Harvard Processor Core

This block is a small processor core. It runs one-word 8-bit instructions from an instruction memory port and works on a separate data memory port. There is no microcode store. A step counter and combinational decode of the opcode, the step and the flags produce every control signal. The step counter changes on the falling clock edge. The program counter, instruction register, register file, flags and halt state change on the rising edge. As a result, each control word is settled half a cycle before the datapath samples it.

The boot logic holds `run_en` low while it fills the instruction memory. When it raises `run_en`, the core starts fetching from address 0. The core runs until it reaches a halt instruction, then raises `halted` and stays frozen until reset. Conditional jumps test a single flag. When the flag is clear, the jump ends after three steps instead of four.

Top module: `cpu8_core`

## Requirements
- R1: Each instruction is one byte with the opcode in bits 7:4, the source register index in bits 3:2 and the destination register index in bits 1:0. The opcodes are 0 NOP, 1 MOV, 2 ADD, 3 SUB, 4 AND, 5 OR, 6 XOR, 7 NOT, 8 LD, 9 ST, A LDI, B JMP, C JZ, D JC, E INC and F HLT.
- R2: ALU instructions write their result to the destination register. They compute ADD dst+src, SUB dst-src, AND, OR, XOR, NOT ~src, INC dst+1 and MOV src.
- R3: Only ADD, SUB, AND, OR, XOR, NOT and INC update the flags. Zero is set when the result is 0. Carry is the carry out of ADD and INC, the borrow of SUB (dst < src), and 0 for the logic operations. MOV, LD, ST and LDI leave both flags unchanged.
- R4: LD loads the data-memory byte at the address held in the source register into the destination register. ST writes the destination register to the address held in the source register. For each ST, `dmem_we` is high for exactly one cycle.
- R5: LDI loads the next instruction byte into the destination register, and execution continues after that byte.
- R6: JMP, and a taken JZ or JC, loads the program counter from the source register. JZ tests only the zero flag and JC tests only the carry flag.
- R7: Every instruction takes three clock cycles (fetch, decode, execute). A taken JZ or JC takes four. An untaken JZ or JC takes three.
- R8: While `run_en` is low between instructions, the core fetches nothing and the program counter holds its value.
- R9: HLT sets `halted`. After that, the program counter and `halted` hold until reset.
- R10: Reset clears the program counter, all four registers, both flags, `halted` and the step counter, and drives `dmem_we` low.
- R11: The program counter changes only on the rising clock edge. The data write strobe changes only on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; datapath on rising edge, control on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Permission to fetch, from the boot logic |
| imem_addr | output | DW | Instruction memory address (program counter) |
| imem_data | input | 8 | Instruction memory read data |
| dmem_addr | output | DW | Data memory address (source register) |
| dmem_wdata | output | DW | Data memory write data (destination register) |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | DW | Data memory read data |
| halted | output | 1 | High once HLT has executed |

## Verification
The hardest state to reach from the ports is a flag value. The flags have no output, so the bench reads them back with small programs. Each program follows the instruction under test with a JZ and a JC over a marker-setting LDI, then stores the markers to data memory. The early exit and the extra branch step are measured by counting cycles from the first fetch to `halted`. The same program is run in taken and untaken variants, and a JC is run with only the zero flag set to show that it ignores that flag.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // opcode field values (instruction bits 7:4)
   typedef enum logic [3:0] {
      OP_NOP = 4'h0, OP_MOV = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
      OP_AND = 4'h4, OP_OR  = 4'h5, OP_XOR = 4'h6, OP_NOT = 4'h7,
      OP_LD  = 4'h8, OP_ST  = 4'h9, OP_LDI = 4'hA, OP_JMP = 4'hB,
      OP_JZ  = 4'hC, OP_JC  = 4'hD, OP_INC = 4'hE, OP_HLT = 4'hF
   } opcode_e;

   typedef enum logic [1:0] {
      ST_FETCH  = 2'd0,
      ST_DECODE = 2'd1,
      ST_EXEC   = 2'd2,
      ST_BRANCH = 2'd3
   } step_e;

   typedef enum logic [1:0] {
      WB_ALU  = 2'd0,
      WB_DMEM = 2'd1,
      WB_IMM  = 2'd2
   } wb_sel_e;

   typedef struct packed {
      logic    ir_ld;
      logic    pc_inc;
      logic    pc_ld;
      logic    reg_we;
      wb_sel_e wb_sel;
      logic    flag_we;
      logic    mem_we;
      logic    halt_set;
   } ctrl_t;

   localparam int unsigned INSN_W  = 8;
   localparam int unsigned OPC_W   = 4;
   localparam int unsigned RIDX_W  = 2;
endpackage

// File: rtl/cpu8_alu.sv
module cpu8_alu
   import cpu8_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  opcode_e         op,
   input  logic [DW-1:0]   dst_val,
   input  logic [DW-1:0]   src_val,
   output logic [DW-1:0]   result,
   output logic            zero,
   output logic            carry
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [DW:0] wide;

   always_comb begin
      wide = '0;
      unique case (op)
         OP_ADD:  wide = {1'b0, dst_val} + {1'b0, src_val};
         OP_SUB:  wide = {1'b0, dst_val} - {1'b0, src_val};
         OP_AND:  wide = {1'b0, dst_val & src_val};
         OP_OR:   wide = {1'b0, dst_val | src_val};
         OP_XOR:  wide = {1'b0, dst_val ^ src_val};
         OP_NOT:  wide = {1'b0, ~src_val};
         OP_INC:  wide = {1'b0, dst_val} + {{DW{1'b0}}, 1'b1};
         default: wide = {1'b0, src_val};
      endcase
   end

   assign result = wide[DW-1:0];
   assign carry  = wide[DW];
   assign zero   = (wide[DW-1:0] == '0);
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile
   import cpu8_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [RIDX_W-1:0] waddr,
   input  logic [DW-1:0]     wdata,
   input  logic [RIDX_W-1:0] raddr_a,
   input  logic [RIDX_W-1:0] raddr_b,
   output logic [DW-1:0]     rdata_a,
   output logic [DW-1:0]     rdata_b
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned NREG = 1 << RIDX_W;

   logic [DW-1:0] rf [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we && (waddr == RIDX_W'(g)))
            q <= wdata;
      end
      assign rf[g] = q;
   end

   assign rdata_a = rf[raddr_a];
   assign rdata_b = rf[raddr_b];
endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
   import cpu8_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    run_en,
   input  logic    halted,
   input  logic    fetched,
   input  opcode_e op,
   input  logic    zf,
   input  logic    cf,
   output step_e   step,
   output ctrl_t   ctrl
);
   timeunit 1ns;
   timeprecision 1ps;

   logic br_true;

   always_comb begin
      br_true = ((op == OP_JZ) && zf) || ((op == OP_JC) && cf);
   end

   // control phase: falling edge
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= ST_FETCH;
      end else begin
         unique case (step)
            ST_FETCH:  step <= fetched ? ST_DECODE : ST_FETCH;
            ST_DECODE: step <= ST_EXEC;
            ST_EXEC:   step <= br_true ? ST_BRANCH : ST_FETCH;
            default:   step <= ST_FETCH;
         endcase
      end
   end

   always_comb begin
      ctrl        = '0;
      ctrl.wb_sel = WB_ALU;
      unique case (step)
         ST_FETCH: begin
            if (run_en && !halted) begin
               ctrl.ir_ld  = 1'b1;
               ctrl.pc_inc = 1'b1;
            end
         end
         ST_EXEC: begin
            unique case (op)
               OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOT, OP_INC: begin
                  ctrl.reg_we  = 1'b1;
                  ctrl.flag_we = 1'b1;
               end
               OP_MOV: ctrl.reg_we = 1'b1;
               OP_LD: begin
                  ctrl.reg_we = 1'b1;
                  ctrl.wb_sel = WB_DMEM;
               end
               OP_ST:  ctrl.mem_we = 1'b1;
               OP_LDI: begin
                  ctrl.reg_we = 1'b1;
                  ctrl.wb_sel = WB_IMM;
                  ctrl.pc_inc = 1'b1;
               end
               OP_JMP: ctrl.pc_ld    = 1'b1;
               OP_HLT: ctrl.halt_set = 1'b1;
               default: ;
            endcase
         end
         ST_BRANCH: ctrl.pc_ld = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
   import cpu8_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_en,
   output logic [DW-1:0] imem_addr,
   input  logic [7:0]    imem_data,
   output logic [DW-1:0] dmem_addr,
   output logic [DW-1:0] dmem_wdata,
   output logic          dmem_we,
   input  logic [DW-1:0] dmem_rdata,
   output logic          halted
);
   timeunit 1ns;
   timeprecision 1ps;

   if (DW < INSN_W) begin : g_dw_chk
      $error("cpu8_core: DW must be at least the instruction width");
   end

   logic [DW-1:0]     pc_q;
   logic [INSN_W-1:0] ir_q;
   logic              zf_q, cf_q, halted_q, fetched_q;
   opcode_e           op;
   logic [RIDX_W-1:0] src_f, dst_f;
   step_e             step;
   ctrl_t             ctrl;
   logic [DW-1:0]     src_val, dst_val, alu_res, imm, wb_data;
   logic              alu_z, alu_c;

   assign op    = opcode_e'(ir_q[INSN_W-1 -: OPC_W]);
   assign src_f = ir_q[2*RIDX_W-1 -: RIDX_W];
   assign dst_f = ir_q[RIDX_W-1:0];

   // immediate widening variant
   if (DW > INSN_W) begin : g_imm_ext
      assign imm = {{(DW-INSN_W){1'b0}}, imem_data};
   end else begin : g_imm_eq
      assign imm = imem_data;
   end

   cpu8_ctrl ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_en  (run_en),
      .halted  (halted_q),
      .fetched (fetched_q),
      .op      (op),
      .zf      (zf_q),
      .cf      (cf_q),
      .step    (step),
      .ctrl    (ctrl)
   );

   cpu8_regfile #(.DW(DW)) rf_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (ctrl.reg_we),
      .waddr   (dst_f),
      .wdata   (wb_data),
      .raddr_a (src_f),
      .raddr_b (dst_f),
      .rdata_a (src_val),
      .rdata_b (dst_val)
   );

   cpu8_alu #(.DW(DW)) alu_i (
      .op      (op),
      .dst_val (dst_val),
      .src_val (src_val),
      .result  (alu_res),
      .zero    (alu_z),
      .carry   (alu_c)
   );

   always_comb begin
      unique case (ctrl.wb_sel)
         WB_DMEM: wb_data = dmem_rdata;
         WB_IMM:  wb_data = imm;
         default: wb_data = alu_res;
      endcase
   end

   // datapath phase: rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q      <= '0;
         ir_q      <= '0;
         zf_q      <= 1'b0;
         cf_q      <= 1'b0;
         halted_q  <= 1'b0;
         fetched_q <= 1'b0;
      end else begin
         fetched_q <= ctrl.ir_ld;
         if (ctrl.ir_ld)
            ir_q <= imem_data;
         if (ctrl.pc_ld)
            pc_q <= src_val;
         else if (ctrl.pc_inc)
            pc_q <= pc_q + DW'(1);
         if (ctrl.flag_we) begin
            zf_q <= alu_z;
            cf_q <= alu_c;
         end
         if (ctrl.halt_set)
            halted_q <= 1'b1;
      end
   end

   assign imem_addr  = pc_q;
   assign dmem_addr  = src_val;
   assign dmem_wdata = dst_val;
   assign dmem_we    = ctrl.mem_we;
   assign halted     = halted_q;
endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk
   import cpu8_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run_en,
   input logic [DW-1:0] imem_addr,
   input logic          dmem_we,
   input logic          halted,
   input step_e         step,
   input opcode_e       op
);
   timeunit 1ns;
   timeprecision 1ps;

   assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |=> !dmem_we);

   assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && $stable(imem_addr)));

   assert_idle_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((step == ST_FETCH) && !run_en) |=> $stable(imem_addr));

   assert_branch_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_BRANCH) |-> ((op == OP_JZ) || (op == OP_JC)));

   assert_branch_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_BRANCH) |=> (step == ST_FETCH));
endmodule

bind cpu8_core cpu8_core_chk #(.DW(DW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_en    (run_en),
   .imem_addr (imem_addr),
   .dmem_we   (dmem_we),
   .halted    (halted),
   .step      (step),
   .op        (op)
);

// File: tb/cpu8_core_tb.sv
module cpu8_core_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_en = 1'b0;
   logic [DW-1:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
   logic [7:0]    imem_data;
   logic          dmem_we, halted;

   logic [7:0] imem [256];
   logic [7:0] dmem [256];

   int n_chk = 0, n_fail = 0, wd = 0, we_cnt = 0, phase_err = 0;
   int cyc;
   logic [DW-1:0] addr_p, pc_hold;
   logic          we_n;

   always #2 clk = ~clk; // 250 MHz

   cpu8_core #(.DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .imem_addr(imem_addr), .imem_data(imem_data),
      .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
      .dmem_rdata(dmem_rdata), .halted(halted)
   );

   assign imem_data  = imem[imem_addr];
   assign dmem_rdata = dmem[dmem_addr];
   always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
   always @(negedge clk) if (dmem_we) we_cnt++;

   // R11 phase monitor
   always @(posedge clk) begin
      #1;
      if (rst_n && (dmem_we !== we_n)) phase_err++;
      addr_p = imem_addr;
   end
   always @(negedge clk) begin
      #1;
      if (rst_n && (imem_addr !== addr_p)) phase_err++;
      we_n = dmem_we;
   end

   localparam logic [3:0] NOP=4'h0, MOV=4'h1, ADD=4'h2, SUB=4'h3, AND_=4'h4, OR_=4'h5,
      XOR_=4'h6, NOT_=4'h7, LD=4'h8, ST=4'h9, LDI=4'hA, JMP=4'hB, JZ=4'hC, JC=4'hD,
      INC=4'hE, HLT=4'hF;

   // {opcode, a, b, result, {6'b0, zero, carry}}
   localparam logic [39:0] VECS [12] = '{
      40'h02_12_34_46_00, 40'h02_F0_10_00_03, 40'h03_50_20_30_00,
      40'h03_10_20_F0_01, 40'h03_33_33_00_02, 40'h04_F0_0F_00_02,
      40'h05_A0_05_A5_00, 40'h06_FF_0F_F0_00, 40'h07_00_0F_F0_00,
      40'h0E_FF_00_00_03, 40'h0E_41_00_42_00, 40'h01_11_99_99_00
   };

   function automatic logic [7:0] enc(input logic [3:0] o, input logic [1:0] s, input logic [1:0] d);
      return {o, s, d};
   endfunction

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) begin imem[i] = 8'h00; dmem[i] = 8'h00; end
   endtask

   task automatic put_ldi(input int at, input logic [1:0] d, input logic [7:0] v);
      imem[at] = enc(LDI, 2'd0, d);
      imem[at+1] = v;
   endtask

   // stores zero marker at 0x81 (0 when Z set) and carry marker at 0x82 (0 when C set)
   task automatic put_flag_tail(input int b);
      put_ldi(b, 2'd0, 8'h00);
      put_ldi(b+2, 2'd3, 8'(b+7));
      imem[b+4] = enc(JZ, 2'd3, 2'd0);
      put_ldi(b+5, 2'd0, 8'h01);
      put_ldi(b+7, 2'd2, 8'h81);
      imem[b+9] = enc(ST, 2'd2, 2'd0);
      put_ldi(b+10, 2'd0, 8'h00);
      put_ldi(b+12, 2'd3, 8'(b+17));
      imem[b+14] = enc(JC, 2'd3, 2'd0);
      put_ldi(b+15, 2'd0, 8'h01);
      put_ldi(b+17, 2'd2, 8'h82);
      imem[b+19] = enc(ST, 2'd2, 2'd0);
      imem[b+20] = enc(HLT, 2'd0, 2'd0);
   endtask

   task automatic run_prog(input int hold);
      rst_n = 1'b0;
      run_en = (hold == 0);
      repeat (2) @(posedge clk);
      #1;
      chk("R10 reset pc", 32'(imem_addr), 0);
      chk("R10 reset halted", 32'(halted), 0);
      chk("R10 reset write strobe", 32'(dmem_we), 0);
      @(negedge clk); #1 rst_n = 1'b1;
      if (hold > 0) begin
         repeat (hold) @(posedge clk);
         #1;
         chk("R8 pc held without run_en", 32'(imem_addr), 0);
         chk("R8 no halt without run_en", 32'(halted), 0);
         @(negedge clk); #1 run_en = 1'b1;
      end
      cyc = 0;
      while (!halted && cyc < 2000) begin
         @(posedge clk); #1; cyc++;
      end
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", wd);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int w0;
      // vector table: R1 R2 R3 R5
      for (int i = 0; i < 12; i++) begin
         clear_mem();
         put_ldi(0, 2'd0, VECS[i][31:24]);
         put_ldi(2, 2'd1, VECS[i][23:16]);
         imem[4] = enc(VECS[i][35:32], 2'd1, 2'd0);
         put_ldi(5, 2'd2, 8'h80);
         imem[7] = enc(ST, 2'd2, 2'd0);
         put_flag_tail(8);
         run_prog(0);
         chk($sformatf("R1 R2 vec %0d result", i), 32'(dmem[8'h80]), 32'(VECS[i][15:8]));
         chk($sformatf("R3 vec %0d zero", i), 32'(dmem[8'h81]), 32'(!VECS[i][1]));
         chk($sformatf("R3 vec %0d carry", i), 32'(dmem[8'h82]), 32'(!VECS[i][0]));
      end

      // R3: MOV and LD keep flags set by INC
      clear_mem();
      put_ldi(0, 2'd0, 8'hFF);
      imem[2] = enc(INC, 2'd0, 2'd0);
      put_ldi(3, 2'd1, 8'h07);
      imem[5] = enc(MOV, 2'd1, 2'd0);
      put_ldi(6, 2'd2, 8'h80);
      imem[8] = enc(ST, 2'd2, 2'd0);
      imem[9] = enc(LD, 2'd2, 2'd1);
      put_flag_tail(10);
      run_prog(0);
      chk("R3 mov value", 32'(dmem[8'h80]), 32'h07);
      chk("R3 zero kept across MOV/LD", 32'(dmem[8'h81]), 0);
      chk("R3 carry kept across MOV/LD", 32'(dmem[8'h82]), 0);

      // R10: registers and flags clear after reset
      clear_mem();
      dmem[0] = 8'hEE;
      imem[0] = enc(ST, 2'd1, 2'd2);
      put_flag_tail(1);
      run_prog(0);
      chk("R10 register cleared", 32'(dmem[0]), 0);
      chk("R10 zero flag cleared", 32'(dmem[8'h81]), 1);
      chk("R10 carry flag cleared", 32'(dmem[8'h82]), 1);

      // R4 R5: LD/ST through pointers, immediate skip
      clear_mem();
      dmem[8'h40] = 8'h5A;
      put_ldi(0, 2'd1, 8'h40);
      imem[2] = enc(LD, 2'd1, 2'd2);
      put_ldi(3, 2'd3, 8'h90);
      imem[5] = enc(ST, 2'd3, 2'd2);
      imem[6] = enc(HLT, 2'd0, 2'd0);
      w0 = we_cnt;
      run_prog(0);
      chk("R4 load/store value", 32'(dmem[8'h90]), 32'h5A);
      chk("R4 one strobe cycle per store", 32'(we_cnt - w0), 1);
      chk("R5 pc after immediates", 32'(imem_addr), 7);
      chk("R7 five plain instructions", 32'(cyc), 15);
      // R9: frozen after halt
      pc_hold = imem_addr;
      repeat (5) @(posedge clk);
      #1;
      chk("R9 halted held", 32'(halted), 1);
      chk("R9 pc held", 32'(imem_addr), 32'(pc_hold));

      // R6 R7: unconditional jump
      clear_mem();
      put_ldi(0, 2'd1, 8'h06);
      imem[2] = enc(JMP, 2'd1, 2'd0);
      put_ldi(3, 2'd0, 8'h11);
      imem[5] = enc(HLT, 2'd0, 2'd0);
      put_ldi(6, 2'd0, 8'h22);
      put_ldi(8, 2'd2, 8'h70);
      imem[10] = enc(ST, 2'd2, 2'd0);
      imem[11] = enc(HLT, 2'd0, 2'd0);
      run_prog(0);
      chk("R6 jump target reached", 32'(dmem[8'h70]), 32'h22);
      chk("R6 halt pc after jump", 32'(imem_addr), 12);
      chk("R7 jump takes three cycles", 32'(cyc), 18);

      // R7 early exit: untaken JZ
      clear_mem();
      imem[0] = enc(INC, 2'd0, 2'd0);
      put_ldi(1, 2'd3, 8'h05);
      imem[3] = enc(JZ, 2'd3, 2'd0);
      imem[4] = enc(HLT, 2'd0, 2'd0);
      imem[5] = enc(HLT, 2'd0, 2'd0);
      run_prog(0);
      chk("R7 untaken JZ cycles", 32'(cyc), 12);
      chk("R6 untaken JZ falls through", 32'(imem_addr), 5);

      // R7 taken JZ
      imem[0] = enc(XOR_, 2'd0, 2'd0);
      run_prog(0);
      chk("R7 taken JZ cycles", 32'(cyc), 13);
      chk("R6 taken JZ target", 32'(imem_addr), 6);

      // R6: JC ignores a set zero flag
      imem[3] = enc(JC, 2'd3, 2'd0);
      run_prog(0);
      chk("R6 JC ignores zero flag", 32'(imem_addr), 5);
      chk("R7 untaken JC cycles", 32'(cyc), 12);

      // R6 R7: taken JC, started after an idle hold (R8)
      clear_mem();
      put_ldi(0, 2'd0, 8'hFF);
      imem[2] = enc(INC, 2'd0, 2'd0);
      put_ldi(3, 2'd3, 8'h07);
      imem[5] = enc(JC, 2'd3, 2'd0);
      imem[6] = enc(HLT, 2'd0, 2'd0);
      imem[7] = enc(HLT, 2'd0, 2'd0);
      run_prog(10);
      chk("R6 taken JC target", 32'(imem_addr), 8);
      chk("R7 taken JC cycles", 32'(cyc), 16);

      chk("R11 phase separation violations", 32'(phase_err), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule